// File: doc/BRIEF.md
# Serial-Loaded Multi-Digit Segment Register

This block takes one digit's worth of display data over a three-wire serial link and writes it into a bank of per-digit output registers. Each register drives a 7-segment pattern plus two indicator (annunciator) bits for one digit. The three link inputs are a data bit, a bit strobe and an active-low write strobe. They are asynchronous to the system clock, so each one passes through a synchronizer, and each strobe edge becomes a single internal event.

A host starts with a write pulse to align the receiver. It then strobes in 8, 9 or 10 bits and issues a write pulse. Once at least eight bits have arrived, an active-low accepted flag goes low, and the next write decodes the 4-bit code and stores it at the addressed digit. If a frame is too long, too short or aimed at a digit that does not exist, the block discards it without touching any digit. The segment font is chosen at elaboration: hexadecimal, or a Code B font that has letters and a blank.

Top module: `serial_digit_reg`

## Requirements
- R1: Each rising edge of `ser_clk_i` counts one bit. `accepted_n_o` is high while fewer than 8 bits are held and goes low once the 8th bit has been counted.
- R2: Bits arrive LSB first. Bits 0 to 3 are the 4-bit digit code, bits 4 to 7 are the digit address, bit 8 enables annunciator 2 and bit 9 enables annunciator 1.
- R3: A falling edge on `wr_n_i` while `accepted_n_o` is low stores the decoded pattern and the annunciator bits in the addressed digit. It then clears the frame, so `accepted_n_o` returns high.
- R4: A falling edge on `wr_n_i` while `accepted_n_o` is high changes no output. It discards the partial frame, so the next bit is taken as bit 0.
- R5: An 11th bit strobe in one frame discards the frame, returning `accepted_n_o` high. A following write changes no output.
- R6: An 8-bit frame leaves both annunciators of the digit off. A 9-bit frame can turn on only annunciator 2. A 10-bit frame can turn on both.
- R7: If the address is `NUM_DIGITS` (10) or more, a write changes no output.
- R8: With `DECODE_MODE`=0 the font is hexadecimal. Segments are active-high, with bit 6 to bit 0 being g,f,e,d,c,b,a. The codes 0 to F give 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R9: With `DECODE_MODE`=1 the codes 0 to 9 give the same patterns as R8. The codes 10 to 15 give '-' 40, 'E' 79, 'H' 76, 'L' 38, 'P' 73 and blank 00.
- R10: Synchronous reset `rst` sets every digit to blank (00), turns every annunciator off and drives `accepted_n_o` high.
- R11: A strobe counts once per edge, however long it is held. Its effect appears within 4 clock cycles of the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_clk_i | input | 1 | Bit strobe; rising edge shifts one bit |
| wr_n_i | input | 1 | Active-low write strobe; falling edge acts |
| accepted_n_o | output | 1 | Low when at least 8 bits are held |
| seg_o | output | NUM_DIGITS*7 | Segment patterns, digit d at [d*7 +: 7] |
| ann1_o | output | NUM_DIGITS | Annunciator 1 per digit |
| ann2_o | output | NUM_DIGITS | Annunciator 2 per digit |

## Verification
The bench builds two copies of the block that share all inputs. One uses the Code B font and the other the hexadecimal font, both with 10 digits. Every frame is therefore checked against both fonts, and codes 10 to 15 show the letters on one copy and hex digits on the other. With 10 digits out of a 4-bit address space, the invalid addresses 10 to 15 can be tested. The 8-bit ready point and the 10-bit limit allow short, full, incomplete and over-long frames to be driven.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
   localparam int SEG_W = 7;
   typedef logic [SEG_W-1:0] seg_t;

   function automatic seg_t font_hex(input logic [3:0] c);
      case (c)
         4'h0: return 7'h3F;  4'h1: return 7'h06;
         4'h2: return 7'h5B;  4'h3: return 7'h4F;
         4'h4: return 7'h66;  4'h5: return 7'h6D;
         4'h6: return 7'h7D;  4'h7: return 7'h07;
         4'h8: return 7'h7F;  4'h9: return 7'h6F;
         4'hA: return 7'h77;  4'hB: return 7'h7C;
         4'hC: return 7'h39;  4'hD: return 7'h5E;
         4'hE: return 7'h79;  default: return 7'h71;
      endcase
   endfunction

   function automatic seg_t font_codeb(input logic [3:0] c);
      case (c)
         4'hA: return 7'h40;
         4'hB: return 7'h79;
         4'hC: return 7'h76;
         4'hD: return 7'h38;
         4'hE: return 7'h73;
         4'hF: return 7'h00;
         default: return font_hex(c);
      endcase
   endfunction
endpackage

// File: rtl/sdr_sync_edge.sv
module sdr_sync_edge #(
   parameter int   STAGES = 2,
   parameter bit   RISE   = 1'b1,
   parameter logic IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic pulse_o
);
   logic [STAGES-1:0] pipe;
   logic              prev;
   logic              lvl;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdr_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pipe <= {STAGES{IDLE}};
         prev <= IDLE;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         prev <= pipe[STAGES-1];
      end
   end

   assign lvl = pipe[STAGES-1];

   generate
      if (RISE) begin : g_rise
         assign pulse_o = lvl & ~prev;
      end else begin : g_fall
         assign pulse_o = ~lvl & prev;
      end
   endgenerate

   // R11: one event per edge
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/sdr_frame_ctl.sv
module sdr_frame_ctl #(
   parameter int DATA_W     = 4,
   parameter int ADDR_W     = 4,
   parameter int NUM_DIGITS = 10,
   parameter int MIN_BITS   = 8,
   parameter int MAX_BITS   = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_i,
   input  logic              shift_i,
   input  logic              write_i,
   output logic              ready_o,
   output logic              commit_o,
   output logic [DATA_W-1:0] code_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ann1_o,
   output logic              ann2_o
);
   localparam int CNT_W = $clog2(MAX_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_BITS);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BITS);

   logic [MAX_BITS-1:0] frame_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [ADDR_W-1:0]   addr_f;
   logic                addr_ok;

   generate
      if (MIN_BITS != DATA_W + ADDR_W) begin : g_bad_min
         $error("sdr_frame_ctl: MIN_BITS must equal DATA_W+ADDR_W");
      end
      if (MAX_BITS != MIN_BITS + 2) begin : g_bad_max
         $error("sdr_frame_ctl: MAX_BITS must equal MIN_BITS+2");
      end
      if (NUM_DIGITS > (1 << ADDR_W)) begin : g_bad_num
         $error("sdr_frame_ctl: NUM_DIGITS exceeds address space");
      end
   endgenerate

   assign addr_f  = frame_q[DATA_W +: ADDR_W];
   assign addr_ok = {1'b0, addr_f} < (ADDR_W+1)'(NUM_DIGITS);
   assign ready_o = cnt_q >= CNT_MIN;

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q  <= '0;
         cnt_q    <= '0;
         commit_o <= 1'b0;
         code_o   <= '0;
         addr_o   <= '0;
         ann1_o   <= 1'b0;
         ann2_o   <= 1'b0;
      end else begin
         commit_o <= 1'b0;
         if (write_i) begin
            if (ready_o && addr_ok) begin
               commit_o <= 1'b1;
               code_o   <= frame_q[DATA_W-1:0];
               addr_o   <= addr_f;
               ann2_o   <= frame_q[MIN_BITS];
               ann1_o   <= frame_q[MIN_BITS+1];
            end
            frame_q <= '0;
            cnt_q   <= '0;
         end else if (shift_i) begin
            if (cnt_q == CNT_MAX) begin
               frame_q <= '0;
               cnt_q   <= '0;
            end else begin
               frame_q[cnt_q] <= bit_i;
               cnt_q          <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R1: the bit that completes the minimum frame raises ready
   a_r1_ready_at_min: assert property (@(posedge clk) disable iff (rst)
      (shift_i && !write_i && cnt_q == CNT_MIN - 1'b1) |=> ready_o);
   // R5: a strobe past the maximum length discards the frame
   a_r5_overflow_clear: assert property (@(posedge clk) disable iff (rst)
      (shift_i && !write_i && cnt_q == CNT_MAX) |=> (cnt_q == '0 && !ready_o));
   // R3/R4: any write leaves the receiver at bit 0
   a_r3_write_realigns: assert property (@(posedge clk) disable iff (rst)
      write_i |=> (cnt_q == '0));
   // R4: no commit without a ready frame
   a_r4_no_early_commit: assert property (@(posedge clk) disable iff (rst)
      (write_i && !ready_o) |=> !commit_o);
endmodule

// File: rtl/sdr_seg_decode.sv
module sdr_seg_decode
   import sdr_pkg::*;
#(
   parameter int MODE = 0
) (
   input  logic [3:0] code_i,
   output seg_t       seg_o
);
   generate
      if (MODE == 0) begin : g_hex
         assign seg_o = font_hex(code_i);
      end else if (MODE == 1) begin : g_codeb
         assign seg_o = font_codeb(code_i);
      end else begin : g_bad_mode
         $error("sdr_seg_decode: MODE must be 0 or 1");
         assign seg_o = '0;
      end
   endgenerate
endmodule

// File: rtl/serial_digit_reg.sv
module serial_digit_reg
   import sdr_pkg::*;
#(
   parameter int NUM_DIGITS  = 10,
   parameter int DATA_W      = 4,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DECODE_MODE = 0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        ser_data_i,
   input  logic                        ser_clk_i,
   input  logic                        wr_n_i,
   output logic                        accepted_n_o,
   output logic [NUM_DIGITS*SEG_W-1:0] seg_o,
   output logic [NUM_DIGITS-1:0]       ann1_o,
   output logic [NUM_DIGITS-1:0]       ann2_o
);
   localparam int MIN_BITS = DATA_W + ADDR_W;
   localparam int MAX_BITS = MIN_BITS + 2;

   logic [SYNC_STAGES-1:0] data_pipe;
   logic                   shift_p, write_p, ready;
   logic                   commit, c_ann1, c_ann2;
   logic [DATA_W-1:0]      c_code;
   logic [ADDR_W-1:0]      c_addr;
   seg_t                   dec_seg;

   generate
      if (DATA_W != 4) begin : g_bad_data
         $error("serial_digit_reg: segment fonts need DATA_W of 4");
      end
   endgenerate

   // data bit takes the same number of stages as the strobes
   always_ff @(posedge clk) begin
      if (rst) data_pipe <= '0;
      else     data_pipe <= {data_pipe[SYNC_STAGES-2:0], ser_data_i};
   end

   sdr_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b1), .IDLE(1'b0)) u_clk_sync (
      .clk(clk), .rst(rst), .din(ser_clk_i), .pulse_o(shift_p));

   sdr_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0), .IDLE(1'b1)) u_wr_sync (
      .clk(clk), .rst(rst), .din(wr_n_i), .pulse_o(write_p));

   sdr_frame_ctl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_DIGITS(NUM_DIGITS),
      .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)
   ) u_ctl (
      .clk(clk), .rst(rst),
      .bit_i(data_pipe[SYNC_STAGES-1]), .shift_i(shift_p), .write_i(write_p),
      .ready_o(ready), .commit_o(commit), .code_o(c_code), .addr_o(c_addr),
      .ann1_o(c_ann1), .ann2_o(c_ann2));

   sdr_seg_decode #(.MODE(DECODE_MODE)) u_dec (.code_i(c_code), .seg_o(dec_seg));

   assign accepted_n_o = ~ready;

   generate
      for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
         always_ff @(posedge clk) begin
            if (rst) begin
               seg_o[d*SEG_W +: SEG_W] <= '0;
               ann1_o[d]               <= 1'b0;
               ann2_o[d]               <= 1'b0;
            end else if (commit && c_addr == ADDR_W'(d)) begin
               seg_o[d*SEG_W +: SEG_W] <= dec_seg;
               ann1_o[d]               <= c_ann1;
               ann2_o[d]               <= c_ann2;
            end
         end
      end
   endgenerate

   // R7: the controller never commits to a missing digit
   a_r7_addr_in_range: assert property (@(posedge clk) disable iff (rst)
      commit |-> ({1'b0, c_addr} < (ADDR_W+1)'(NUM_DIGITS)));
   // R4: outputs move only after a commit
   a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
      !commit |=> ($stable(seg_o) && $stable(ann1_o) && $stable(ann2_o)));
   // R3: a commit follows a write seen while ready
   a_r3_commit_after_write: assert property (@(posedge clk) disable iff (rst)
      commit |-> $past(write_p && ready));
endmodule

// File: tb/tb_serial_digit_reg.sv
module tb_serial_digit_reg;
   localparam int ND = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sdat = 1'b0, sclk = 1'b0, wr_n = 1'b1;
   logic acc_b, acc_h;
   logic [ND*7-1:0] seg_b, seg_h;
   logic [ND-1:0]   a1_b, a2_b, a1_h, a2_h;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [ND*7-1:0] m_seg_b, m_seg_h;
   logic [ND-1:0]   m_a1, m_a2;

   always #5 clk = ~clk;

   serial_digit_reg #(.DECODE_MODE(1)) dut (
      .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk), .wr_n_i(wr_n),
      .accepted_n_o(acc_b), .seg_o(seg_b), .ann1_o(a1_b), .ann2_o(a2_b));

   serial_digit_reg #(.DECODE_MODE(0)) dut_hex (
      .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk), .wr_n_i(wr_n),
      .accepted_n_o(acc_h), .seg_o(seg_h), .ann1_o(a1_h), .ann2_o(a2_h));

   // fonts written from R8 and R9
   function automatic logic [6:0] exp_hex(input logic [3:0] c);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[c];
   endfunction
   function automatic logic [6:0] exp_cb(input logic [3:0] c);
      logic [6:0] t [6] = '{7'h40, 7'h79, 7'h76, 7'h38, 7'h73, 7'h00};
      return (c < 10) ? exp_hex(c) : t[c - 10];
   endfunction

   task automatic check(input bit ok, input string req, input logic [79:0] act,
                        input logic [79:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(seg_b == m_seg_b, {req, " codeb seg"}, 80'(seg_b), 80'(m_seg_b));
      check(seg_h == m_seg_h, {req, " hex seg"}, 80'(seg_h), 80'(m_seg_h));
      check(a1_b == m_a1 && a1_h == m_a1, {req, " ann1"}, 80'({a1_b, a1_h}), 80'({m_a1, m_a1}));
      check(a2_b == m_a2 && a2_h == m_a2, {req, " ann2"}, 80'({a2_b, a2_h}), 80'({m_a2, m_a2}));
   endtask

   task automatic check_acc(input logic exp, input string req);
      check(acc_b == exp && acc_h == exp, req, 80'({acc_b, acc_h}), 80'({exp, exp}));
   endtask

   task automatic strobe_bit(input logic b, input int hold);
      @(negedge clk); sdat = b;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (hold) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_write();
      @(negedge clk); wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_bits(input logic [10:0] f, input int n);
      for (int i = 0; i < n; i++) strobe_bit(f[i], 4);
   endtask

   task automatic model_write(input int addr, input logic [3:0] code,
                              input logic an1, input logic an2);
      m_seg_b[addr*7 +: 7] = exp_cb(code);
      m_seg_h[addr*7 +: 7] = exp_hex(code);
      m_a1[addr] = an1;
      m_a2[addr] = an2;
   endtask

   // {nbits, addr, code, an1, an2}
   localparam logic [13:0] VEC [10] = '{
      {4'd10, 4'd0, 4'h0, 1'b1, 1'b1},
      {4'd10, 4'd1, 4'hA, 1'b1, 1'b0},
      {4'd9,  4'd2, 4'hB, 1'b0, 1'b1},
      {4'd8,  4'd3, 4'hC, 1'b0, 1'b0},
      {4'd10, 4'd4, 4'hD, 1'b0, 1'b1},
      {4'd10, 4'd5, 4'hE, 1'b1, 1'b1},
      {4'd8,  4'd6, 4'hF, 1'b0, 1'b0},
      {4'd10, 4'd9, 4'h9, 1'b1, 1'b0},
      {4'd10, 4'd7, 4'h7, 1'b0, 1'b0},
      {4'd9,  4'd8, 4'h5, 1'b0, 1'b1}};

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      m_seg_b = '0; m_seg_h = '0; m_a1 = '0; m_a2 = '0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      // R10 reset state
      check_all("R10 reset");
      check_acc(1'b1, "R10 accepted_n after reset");

      pulse_write();
      // R2 R3 R6 R8 R9 table of frames
      foreach (VEC[k]) begin
         logic [3:0] nb, ad, cd;
         logic an1, an2;
         {nb, ad, cd, an1, an2} = VEC[k];
         send_bits({1'b0, an1, an2, ad, cd}, int'(nb));
         check_acc(1'b0, "R1 accepted_n low before write");
         pulse_write();
         model_write(int'(ad), cd, an1, an2);
         check_all("R3 R6 R8 R9 table frame");
         check_acc(1'b1, "R3 accepted_n high after write");
      end

      // R1 R11: seventh bit held long counts once
      send_bits(11'h000, 6);
      strobe_bit(1'b0, 25);
      check_acc(1'b1, "R11 long strobe counted once (7 bits)");
      strobe_bit(1'b0, 4);
      check_acc(1'b0, "R1 low after 8th bit");
      pulse_write();
      model_write(0, 4'h0, 1'b0, 1'b0);
      check_all("R6 8-bit frame clears annunciators of digit 0");

      // R4: partial frame then write does nothing, next frame aligned
      send_bits(11'h7FF, 5);
      check_acc(1'b1, "R4 partial frame not accepted");
      pulse_write();
      check_all("R4 write while not ready");
      send_bits({1'b0, 1'b1, 1'b1, 4'd2, 4'h3}, 10);
      pulse_write();
      model_write(2, 4'h3, 1'b1, 1'b1);
      check_all("R4 frame after resync aligned");

      // R5: eleven strobes discard frame
      send_bits({1'b0, 1'b1, 1'b1, 4'd4, 4'h8}, 10);
      check_acc(1'b0, "R5 ten bits accepted");
      strobe_bit(1'b1, 4);
      check_acc(1'b1, "R5 eleventh bit clears frame");
      pulse_write();
      check_all("R5 write after overflow");

      // R7: invalid addresses
      send_bits({1'b0, 1'b1, 1'b1, 4'd12, 4'h1}, 10);
      check_acc(1'b0, "R7 frame accepted");
      pulse_write();
      check_all("R7 address 12 ignored");
      send_bits({1'b0, 1'b0, 1'b0, 4'd10, 4'h2}, 8);
      pulse_write();
      check_all("R7 address 10 ignored");
      check_acc(1'b1, "R7 accepted_n high after ignored write");

      // R10: reset mid-frame clears everything
      send_bits(11'h0FF, 8);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk); rst = 1'b0;
      repeat (2) @(negedge clk);
      m_seg_b = '0; m_seg_h = '0; m_a1 = '0; m_a2 = '0;
      check_all("R10 reset after use");
      check_acc(1'b1, "R10 accepted_n after second reset");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule